// File: doc/BRIEF.md
# Fully Associative Assist Line Buffer

This block is a small, fully associative line buffer. It sits next to a large direct-mapped data cache, and the two are searched in the same cycle. A lookup presents a line tag. In that same cycle the block answers with a hit flag and the stored line data. Every refill that follows a miss is written into this buffer and never directly into the direct-mapped cache. The buffer therefore soaks up conflict misses that would otherwise thrash a single direct-mapped set.

Entries are replaced in strict arrival order by a wrapping pointer. Each refill carries a flag from the requesting access saying that the data is expected to show only spatial locality, and the entry keeps that flag. When an occupied entry is overwritten, its flag decides what happens to the old line:
- If the flag is set, the old line is dropped.
- If the flag is clear, the old line is offered on a writeback port to the direct-mapped cache.

When the old line has to be offered, the refill waits until that port accepts it.

Top module: `fa_assist_cache`

## Requirements
- R1: After reset every entry is empty, so every lookup misses. No writeback is offered and `fill_ready` is high.
- R2: A lookup whose tag matches a stored line raises `lk_hit` in the same cycle and returns that line's data on `lk_data`.
- R3: A lookup of a tag that is not stored gives `lk_hit` low. `lk_hit` is also low whenever `lk_valid` is low.
- R4: The entry overwritten by a refill is always the one filled longest ago, counting accepted refills only.
- R5: While the entry to be overwritten is still empty, a refill offers no writeback and is accepted at once.
- R6: When the line to be overwritten has its spatial-only flag clear, the refill raises `wb_valid` and presents that line's tag on `wb_tag` and its data on `wb_data`.
- R7: When the line to be overwritten has its spatial-only flag set, the line is dropped. `wb_valid` stays low and the refill is accepted whatever the state of `wb_ready`.
- R8: While a writeback is offered and `wb_ready` is low, `fill_ready` is low and the buffer's contents and order do not change.
- R9: After an accepted refill, the replaced tag misses and the new tag hits with its new data.
- R10: No tag is stored in more than one entry, so the data of a hit is exactly the data of one line.
- R11: The replacement pointer wraps after the last entry. The refill that follows a full pass replaces the first entry written in that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the release is synchronised inside the block |
| lk_valid | input | 1 | Lookup request |
| lk_tag | input | TAG_W | Line tag to look up |
| lk_hit | output | 1 | Lookup hit, valid in the same cycle |
| lk_data | output | LINE_W | Data of the hitting line; zero on a miss |
| fill_valid | input | 1 | Refill request |
| fill_tag | input | TAG_W | Tag of the refilled line; must not already be stored |
| fill_data | input | LINE_W | Refill line data |
| fill_spatial | input | 1 | Spatial-only flag of the requesting access |
| fill_ready | output | 1 | The refill is taken on a clock edge where this and `fill_valid` are both high |
| wb_valid | output | 1 | Replaced line offered to the direct-mapped cache |
| wb_tag | output | TAG_W | Tag of the offered line |
| wb_data | output | LINE_W | Data of the offered line |
| wb_ready | input | 1 | Direct-mapped cache accepts the offered line |

## Verification
The bench keeps its own model of the arrival order, tags and flags, so a pointer that is off by one or steps without an accepted refill shows up on the next refill. It appears there as the wrong `wb_tag`, or as `wb_valid` disagreeing with the flag of the expected victim. A corrupted valid or flag bit shows either as a lookup that misses when it should hit, or as a writeback offered out of an empty or dropped entry. Either one appears in the cycle the entry is next looked up or replaced. A duplicated tag shows at once as OR-merged data on `lk_data`.

// File: rtl/fac_pkg.sv
package fac_pkg;
  localparam int unsigned FAC_ENTRIES = 64;
  localparam int unsigned FAC_TAG_W   = 28;
  localparam int unsigned FAC_LINE_W  = 64;
endpackage

// File: rtl/fac_rst_sync.sv
module fac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fac_fifo_ptr.sv
module fac_fifo_ptr #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned PTR_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;

  // next-state: step by one per accepted refill, wrap after the last entry
  always_comb begin
    ptr_d = ptr_q;
    if (advance) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (advance) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/fac_tag_store.sv
module fac_tag_store #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned TAG_W   = 28,
  parameter int unsigned LINE_W  = 64,
  localparam int unsigned PTR_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  // write port (victim slot)
  input  logic               wr_en,
  input  logic [PTR_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [LINE_W-1:0]  wr_data,
  input  logic               wr_hint,
  // search port
  input  logic [TAG_W-1:0]   srch_tag,
  output logic [ENTRIES-1:0] match_vec,
  output logic [LINE_W-1:0]  srch_data,
  // victim read-out at wr_idx
  output logic               vic_valid,
  output logic               vic_hint,
  output logic [TAG_W-1:0]   vic_tag,
  output logic [LINE_W-1:0]  vic_data
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] hint_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [LINE_W-1:0]  data_q [ENTRIES];

  // valid bits: the only state cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  // payload: written with an explicit enable, never reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
      hint_q[wr_idx] <= wr_hint;
    end
  end

  // one comparator per entry, all evaluated in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (tag_q[g] == srch_tag);
  end

  // AND-OR select driven by the one-hot match vector
  always_comb begin
    srch_data = '0;
    for (int i = 0; i < ENTRIES; i++)
      srch_data = srch_data | ({LINE_W{match_vec[i]}} & data_q[i]);
  end

  assign vic_valid = valid_q[wr_idx];
  assign vic_hint  = hint_q[wr_idx];
  assign vic_tag   = tag_q[wr_idx];
  assign vic_data  = data_q[wr_idx];
endmodule

// File: rtl/fac_evict_ctrl.sv
module fac_evict_ctrl (
  input  logic fill_valid,
  input  logic vic_valid,
  input  logic vic_hint,
  input  logic wb_ready,
  output logic wb_valid,
  output logic fill_ready,
  output logic fill_fire
);
  logic keep_victim;

  // an occupied victim without the spatial-only flag must move to the
  // direct-mapped cache before its slot is reused
  assign keep_victim = vic_valid && !vic_hint;
  assign wb_valid    = fill_valid && keep_victim;
  assign fill_ready  = !keep_victim || wb_ready;
  assign fill_fire   = fill_valid && fill_ready;
endmodule

// File: rtl/fa_assist_cache.sv
module fa_assist_cache
  import fac_pkg::*;
#(
  parameter int unsigned ENTRIES = FAC_ENTRIES,
  parameter int unsigned TAG_W   = FAC_TAG_W,
  parameter int unsigned LINE_W  = FAC_LINE_W,
  localparam int unsigned PTR_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [LINE_W-1:0] lk_data,
  input  logic              fill_valid,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_data,
  input  logic              fill_spatial,
  output logic              fill_ready,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [LINE_W-1:0] wb_data,
  input  logic              wb_ready
);
  logic               rst_sync_n;
  logic [PTR_W-1:0]   fifo_ptr;
  logic               fill_fire;
  logic [ENTRIES-1:0] match_vec;
  logic [LINE_W-1:0]  srch_data;
  logic               vic_valid;
  logic               vic_hint;

  fac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fac_fifo_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .advance (fill_fire),
    .ptr     (fifo_ptr)
  );

  fac_tag_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (fill_fire),
    .wr_idx    (fifo_ptr),
    .wr_tag    (fill_tag),
    .wr_data   (fill_data),
    .wr_hint   (fill_spatial),
    .srch_tag  (lk_tag),
    .match_vec (match_vec),
    .srch_data (srch_data),
    .vic_valid (vic_valid),
    .vic_hint  (vic_hint),
    .vic_tag   (wb_tag),
    .vic_data  (wb_data)
  );

  fac_evict_ctrl u_evict (
    .fill_valid (fill_valid),
    .vic_valid  (vic_valid),
    .vic_hint   (vic_hint),
    .wb_ready   (wb_ready),
    .wb_valid   (wb_valid),
    .fill_ready (fill_ready),
    .fill_fire  (fill_fire)
  );

  assign lk_hit  = lk_valid && (|match_vec);
  assign lk_data = lk_valid ? srch_data : '0;
endmodule

// File: rtl/fac_checker.sv
module fac_checker #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned PTR_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fill_valid,
  input logic               fill_ready,
  input logic               wb_valid,
  input logic               wb_ready,
  input logic               vic_valid,
  input logic               vic_hint,
  input logic [ENTRIES-1:0] match_vec,
  input logic [PTR_W-1:0]   fifo_ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  a_r8_stall_blocks_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |-> !fill_ready);

  a_r7_flagged_victim_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && vic_valid && vic_hint) |-> (!wb_valid && fill_ready));

  a_r5_empty_slot_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !vic_valid) |-> (!wb_valid && fill_ready));

  a_r11_ptr_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=>
      (fifo_ptr == (($past(fifo_ptr) == LAST) ? '0 : $past(fifo_ptr) + 1'b1)));

  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fill_ready) |=> $stable(fifo_ptr));
endmodule

bind fa_assist_cache fac_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready),
  .wb_valid   (wb_valid),
  .wb_ready   (wb_ready),
  .vic_valid  (vic_valid),
  .vic_hint   (vic_hint),
  .match_vec  (match_vec),
  .fifo_ptr   (fifo_ptr)
);

// File: tb/fa_assist_cache_tb_top.sv
module fa_assist_cache_tb_top;
  localparam int N      = 64;
  localparam int TAG_W  = 28;
  localparam int LINE_W = 64;

  logic              clk;
  logic              rst_n;
  logic              lk_valid;
  logic [TAG_W-1:0]  lk_tag;
  logic              lk_hit;
  logic [LINE_W-1:0] lk_data;
  logic              fill_valid;
  logic [TAG_W-1:0]  fill_tag;
  logic [LINE_W-1:0] fill_data;
  logic              fill_spatial;
  logic              fill_ready;
  logic              wb_valid;
  logic [TAG_W-1:0]  wb_tag;
  logic [LINE_W-1:0] wb_data;
  logic              wb_ready;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model of the buffer
  logic [TAG_W-1:0] m_tag  [N];
  bit               m_val  [N];
  bit               m_hint [N];
  int               m_ptr;

  fa_assist_cache #(.ENTRIES(N), .TAG_W(TAG_W), .LINE_W(LINE_W)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .lk_valid (lk_valid), .lk_tag (lk_tag), .lk_hit (lk_hit), .lk_data (lk_data),
    .fill_valid (fill_valid), .fill_tag (fill_tag), .fill_data (fill_data),
    .fill_spatial (fill_spatial), .fill_ready (fill_ready),
    .wb_valid (wb_valid), .wb_tag (wb_tag), .wb_data (wb_data), .wb_ready (wb_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  function automatic logic [LINE_W-1:0] mk_data(input logic [TAG_W-1:0] t);
    logic [31:0] a;
    a = 32'(t);
    return {a * 32'h9E37_79B1, a ^ 32'hC3C3_5A00};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [TAG_W-1:0] t, input bit exp_hit, input string rq);
    @(negedge clk);
    lk_valid = 1'b1; lk_tag = t;
    #2;
    chk(lk_hit == exp_hit, rq, "lk_hit", LINE_W'(lk_hit), LINE_W'(exp_hit));
    if (exp_hit)
      chk(lk_data == mk_data(t), rq, "lk_data", lk_data, mk_data(t));
    lk_valid = 1'b0;
  endtask

  task automatic do_fill(input logic [TAG_W-1:0] t, input bit hint);
    bit    exp_wb;
    string rq;
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = t; fill_data = mk_data(t); fill_spatial = hint;
    exp_wb = m_val[m_ptr] && !m_hint[m_ptr];
    rq = !m_val[m_ptr] ? "R5" : (m_hint[m_ptr] ? "R7" : "R6");
    #2;
    chk(wb_valid == exp_wb, rq, "wb_valid", LINE_W'(wb_valid), LINE_W'(exp_wb));
    if (exp_wb) begin
      chk(wb_tag == m_tag[m_ptr], "R4", "wb_tag", LINE_W'(wb_tag), LINE_W'(m_tag[m_ptr]));
      chk(wb_data == mk_data(m_tag[m_ptr]), "R6", "wb_data", wb_data, mk_data(m_tag[m_ptr]));
    end else begin
      chk(fill_ready == 1'b1, rq, "fill_ready", LINE_W'(fill_ready), 1);
    end
    while (!fill_ready) begin
      @(negedge clk); #2;
    end
    @(posedge clk);
    #1 fill_valid = 1'b0;
    m_tag[m_ptr] = t; m_val[m_ptr] = 1'b1; m_hint[m_ptr] = hint;
    m_ptr = (m_ptr + 1) % N;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk(fill_ready == 1'b1, "R1", "fill_ready", LINE_W'(fill_ready), 1);
    chk(wb_valid == 1'b0, "R1", "wb_valid", LINE_W'(wb_valid), 0);
    lookup(28'h100, 1'b0, "R1");
    lookup(28'h0, 1'b0, "R1");
  endtask

  task automatic t_cold_fill;
    wb_ready = 1'b0;   // no writeback may be needed: R5
    for (int i = 0; i < N; i++) do_fill(TAG_W'(28'h100 + i), i[0]);
    for (int i = 0; i < N; i++) lookup(TAG_W'(28'h100 + i), 1'b1, "R2");  // R10 via exact data
    lookup(28'h999, 1'b0, "R3");
    @(negedge clk);
    lk_valid = 1'b0; lk_tag = 28'h105;
    #2;
    chk(lk_hit == 1'b0, "R3", "lk_hit idle", LINE_W'(lk_hit), 0);
  endtask

  task automatic t_evict_keep;
    wb_ready = 1'b1;
    do_fill(28'h200, 1'b0);          // victim 0x100, flag clear: R6
    lookup(28'h100, 1'b0, "R9");
    lookup(28'h200, 1'b1, "R9");
    lookup(28'h101, 1'b1, "R4");     // next oldest untouched
  endtask

  task automatic t_evict_drop;
    wb_ready = 1'b0;
    do_fill(28'h201, 1'b0);          // victim 0x101, flag set: R7
    lookup(28'h101, 1'b0, "R7");
    lookup(28'h201, 1'b1, "R9");
  endtask

  task automatic t_stall;
    wb_ready = 1'b0;
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = 28'h202; fill_data = mk_data(28'h202); fill_spatial = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #2;
      chk(fill_ready == 1'b0, "R8", "fill_ready", LINE_W'(fill_ready), 0);
      chk(wb_valid == 1'b1, "R8", "wb_valid", LINE_W'(wb_valid), 1);
      chk(wb_tag == 28'h102, "R8", "wb_tag", LINE_W'(wb_tag), 28'h102);
      lk_valid = 1'b1; lk_tag = 28'h102;
      #1;
      chk(lk_hit == 1'b1, "R8", "old line hit", LINE_W'(lk_hit), 1);
      lk_tag = 28'h202;
      #1;
      chk(lk_hit == 1'b0, "R8", "new line early", LINE_W'(lk_hit), 0);
      lk_valid = 1'b0;
      @(negedge clk);
    end
    wb_ready = 1'b1;
    #2;
    chk(fill_ready == 1'b1, "R8", "fill_ready release", LINE_W'(fill_ready), 1);
    @(posedge clk);
    #1 fill_valid = 1'b0;
    m_tag[m_ptr] = 28'h202; m_val[m_ptr] = 1'b1; m_hint[m_ptr] = 1'b1;
    m_ptr = (m_ptr + 1) % N;
    lookup(28'h202, 1'b1, "R9");
    lookup(28'h102, 1'b0, "R9");
  endtask

  task automatic t_wrap;
    wb_ready = 1'b1;
    for (int i = 3; i < N; i++) do_fill(TAG_W'(28'h200 + i), (i % 3) == 0);
    do_fill(28'h300, 1'b0);          // wraps: victim is 0x200 in entry 0
    lookup(28'h200, 1'b0, "R11");
    lookup(28'h300, 1'b1, "R11");
    do_fill(28'h301, 1'b1);          // victim 0x201, flag clear
    lookup(28'h201, 1'b0, "R11");
    lookup(28'h23F, 1'b1, "R2");
  endtask

  initial begin
    lk_valid = 0; lk_tag = '0; fill_valid = 0; fill_tag = '0; fill_data = '0;
    fill_spatial = 0; wb_ready = 0; m_ptr = 0;
    for (int i = 0; i < N; i++) begin m_val[i] = 0; m_hint[i] = 0; m_tag[i] = '0; end
    t_reset();
    t_cold_fill();
    t_evict_keep();
    t_evict_drop();
    t_stall();
    t_wrap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule